// File: doc/BRIEF.md
# Programmable Interval Timer

A register-mapped timer with a 32-bit word interface. Software programs a reload value, then drives a down-counter through a control word whose two low bits carry a command (load, stop, run) and whose upper bits choose one of four internal counting rates. When the counter expires it latches a raw interrupt bit. A mask register decides whether that bit reaches the interrupt pin. Software clears the bit by writing a one to the acknowledge register.

A free-running time register returns a value that grows on every clock cycle, so any two reads return different values. A second channel occupies its own register slots and keeps what software writes to them, but it never counts.

Top module: `intv_timer`

## Requirements
- R1: After reset, every divisor, control and mask register reads 0, the counter is stopped at 0, no raw bit is set, `irq_o` is low and `bus_rdata` is 0.
- R2: Offsets within the block: channel 0 divisor 0x00, count 0x04, control 0x08. Channel 1 divisor 0x10, count 0x14, control 0x18. Time 0x38, mask 0x48, acknowledge 0x4C, raw 0x50, masked 0x54. Channel 1 keeps its divisor and control words for readback, and its count always reads 0.
- R3: Control bits [4:2] choose the rate. A free-running 3-bit prescaler starts at 0 after reset. Code 7 ticks on every cycle. Codes 6, 5 and 4 tick on the cycles where the prescaler's low 1, 2 or 3 bits are all ones. Codes 0 to 3 never tick, so a running counter does not move.
- R4: Control bits [1:0] are the command. 0 copies the divisor into the counter and leaves the run state as it was. 1 stops the counter. 2 starts it. A write with command 3 is ignored in full, including its rate bits. An accepted control write suppresses counting in that cycle. Control reads back the last accepted bits [4:0].
- R5: On each tick while running, a nonzero counter decrements by one. A zero counter instead reloads from the divisor and sets raw bit 0, so the period is divisor+1 ticks.
- R6: `irq_o` is high exactly when raw bit 0 and mask bit 0 are both set. The masked register reads raw AND mask (bits [1:0]).
- R7: A write to the acknowledge register clears each raw bit written as 1. An expiry in the same cycle wins, and the bit stays set.
- R8: The time register returns a cycle count that advances by one per clock, so two back-to-back reads differ by exactly 1.
- R9: Writes to the count, time, raw and masked registers change nothing. Unmapped offsets and the acknowledge register read as 0.
- R10: `bus_rdata` is registered. It carries the addressed value in the cycle after `bus_re` and holds that value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Word write strobe |
| bus_re | input | 1 | Word read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Masked timer interrupt |

## Verification
The first patterns run the counter at the fastest rate with small divisors, including divisor 0. These show whether the period is divisor+1, and whether an expiry that meets an acknowledge in the same cycle is kept. Runs at the slower codes separate the prescaler phases from one another. Runs with codes 0 to 3 and with command 3 must leave the count and the control word untouched. Toggling the mask while a raw bit is pending separates the gated pin from the raw state. Writes to read-only and unmapped offsets, together with the dormant second channel, confirm that decoding touches only the addressed register.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  localparam int PRE_W     = 3;
  localparam int CTRL_W    = 5;
  localparam int NCH       = 2;
  localparam int CH_STRIDE = 16;

  localparam logic [7:0] OFS_DIV0  = 8'h00;
  localparam logic [7:0] OFS_CNT0  = 8'h04;
  localparam logic [7:0] OFS_CTRL0 = 8'h08;
  localparam logic [7:0] OFS_TIME  = 8'h38;
  localparam logic [7:0] OFS_MASK  = 8'h48;
  localparam logic [7:0] OFS_ACK   = 8'h4C;
  localparam logic [7:0] OFS_RAW   = 8'h50;
  localparam logic [7:0] OFS_MSKD  = 8'h54;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_STOP = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  // rate code 7 -> shift 0 (every cycle) ... code 4 -> shift 3 (every 8th)
  function automatic logic [1:0] rate_shift(input logic [2:0] sel);
    return 2'd3 - sel[1:0];
  endfunction

  function automatic logic tick_hit(input logic [2:0] sel, input logic [PRE_W-1:0] pre);
    logic [PRE_W-1:0] m;
    m = (3'b001 << rate_shift(sel)) - 3'b001;
    return sel[2] && ((pre & m) == m);
  endfunction
endpackage

// File: rtl/intv_timer_prescale.sv
module intv_timer_prescale
  import intv_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] pre_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/intv_timer_chan.sv
module intv_timer_chan
  import intv_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter bit ACTIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_we,
  input  logic              ctrl_we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [PRE_W-1:0]  pre,
  output logic [CNT_W-1:0]  div_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              expire
);
  op_e  wop;
  logic accept;

  assign wop    = op_e'(wdata[1:0]);
  assign accept = ctrl_we && (wop != OP_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (div_we) div_q  <= wdata;
      if (accept) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  generate
    if (ACTIVE) begin : g_count
      logic run_q;
      logic tick;

      assign tick   = run_q && tick_hit(ctrl_q[4:2], pre);
      assign expire = tick && !accept && (cnt_q == '0);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else if (accept) begin
          unique case (wop)
            OP_LOAD: cnt_q <= div_q;
            OP_STOP: run_q <= 1'b0;
            OP_RUN:  run_q <= 1'b1;
            default: run_q <= run_q;
          endcase
        end else if (tick) begin
          cnt_q <= (cnt_q == '0) ? div_q : cnt_q - 1'b1;
        end
      end

      AST_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !accept && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
      AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !accept) |=> $stable(cnt_q)); // R4
      AST_BADSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[4] && !accept) |=> $stable(cnt_q)); // R3
    end else begin : g_dormant
      logic unused_pre;
      assign unused_pre = ^pre;
      assign cnt_q      = '0;
      assign expire     = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/intv_timer_irq.sv
module intv_timer_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] expire,
  input  logic           mask_we,
  input  logic           ack_we,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] mask_q,
  output logic           irq_o
);
  logic [NCH-1:0] clr;

  assign clr   = ack_we ? wbits : '0;
  assign irq_o = |(raw_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | expire;
      if (mask_we) mask_q <= wbits;
    end
  end

  AST_EXPIRE_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> raw_q[0]); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && wbits[0] && !expire[0]) |=> !raw_q[0]); // R7
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int TIME_W = DATA_W;

  logic [PRE_W-1:0]  pre;
  logic [CNT_W-1:0]  div_a  [NCH];
  logic [CTRL_W-1:0] ctrl_a [NCH];
  logic [CNT_W-1:0]  cnt_a  [NCH];
  logic [NCH-1:0]    expire;
  logic [NCH-1:0]    raw_q, mask_q;
  logic [TIME_W-1:0] time_q;
  logic [DATA_W-1:0] rd_d;
  logic              mask_we, ack_we;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  intv_timer_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .pre_q (pre)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic div_we, ctrl_we;
    assign div_we  = bus_we && hit(bus_addr, OFS_DIV0  + 8'(c * CH_STRIDE));
    assign ctrl_we = bus_we && hit(bus_addr, OFS_CTRL0 + 8'(c * CH_STRIDE));

    intv_timer_chan #(.CNT_W(CNT_W), .ACTIVE(c == 0)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_we  (div_we),
      .ctrl_we (ctrl_we),
      .wdata   (bus_wdata[CNT_W-1:0]),
      .pre     (pre),
      .div_q   (div_a[c]),
      .ctrl_q  (ctrl_a[c]),
      .cnt_q   (cnt_a[c]),
      .expire  (expire[c])
    );
  end

  assign mask_we = bus_we && hit(bus_addr, OFS_MASK);
  assign ack_we  = bus_we && hit(bus_addr, OFS_ACK);

  intv_timer_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .wbits   (bus_wdata[NCH-1:0]),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_q + 1'b1;
  end

  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit(bus_addr, OFS_DIV0  + 8'(c * CH_STRIDE))) rd_d[CNT_W-1:0]  = div_a[c];
      if (hit(bus_addr, OFS_CNT0  + 8'(c * CH_STRIDE))) rd_d[CNT_W-1:0]  = cnt_a[c];
      if (hit(bus_addr, OFS_CTRL0 + 8'(c * CH_STRIDE))) rd_d[CTRL_W-1:0] = ctrl_a[c];
    end
    if (hit(bus_addr, OFS_TIME)) rd_d[TIME_W-1:0] = time_q;
    if (hit(bus_addr, OFS_MASK)) rd_d[NCH-1:0]    = mask_q;
    if (hit(bus_addr, OFS_RAW))  rd_d[NCH-1:0]    = raw_q;
    if (hit(bus_addr, OFS_MSKD)) rd_d[NCH-1:0]    = raw_q & mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_d;
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> time_q == $past(time_q) + 1'b1); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/intv_timer_tb.sv
module intv_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we, bus_re;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  intv_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_div [2];
  logic [4:0]  m_ctrl [2];
  logic [31:0] m_cnt0;
  bit          m_run0;
  logic [1:0]  m_raw, m_mask;
  logic [31:0] m_time;
  int          m_pre;
  logic [31:0] m_rdata;
  string       m_rtag;
  bit          m_irq;
  int          per;
  bit          tk, acc0, fire;

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return m_div[0];
      8'h04: return m_cnt0;
      8'h08: return {27'd0, m_ctrl[0]};
      8'h10: return m_div[1];
      8'h18: return {27'd0, m_ctrl[1]};
      8'h38: return m_time;
      8'h48: return {30'd0, m_mask};
      8'h50: return {30'd0, m_raw};
      8'h54: return {30'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string mtag(input logic [7:0] a);
    case (a)
      8'h04: return "R5";
      8'h08: return "R4";
      8'h00, 8'h10, 8'h14, 8'h18: return "R2";
      8'h38: return "R8";
      8'h48, 8'h54: return "R6";
      8'h50: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div[0] = 0; m_div[1] = 0; m_ctrl[0] = 0; m_ctrl[1] = 0;
      m_cnt0 = 0; m_run0 = 0; m_raw = 0; m_mask = 0; m_time = 0; m_pre = 0;
      m_rdata = 0; m_rtag = "R1"; m_irq = 0;
    end else begin
      if (bus_re) begin
        m_rdata = mread(bus_addr);
        m_rtag  = mtag(bus_addr);
      end else begin
        m_rtag = "R10";
      end
      per  = 1 << (7 - int'(m_ctrl[0][4:2]));
      tk   = m_run0 && m_ctrl[0][4] && ((m_pre % per) == per - 1);
      acc0 = bus_we && bus_addr == 8'h08 && bus_wdata[1:0] != 2'd3;
      fire = tk && !acc0 && m_cnt0 == 0;
      if (acc0) begin
        m_ctrl[0] = bus_wdata[4:0];
        if (bus_wdata[1:0] == 2'd0) m_cnt0 = m_div[0];
        if (bus_wdata[1:0] == 2'd1) m_run0 = 0;
        if (bus_wdata[1:0] == 2'd2) m_run0 = 1;
      end else if (tk) begin
        m_cnt0 = (m_cnt0 == 0) ? m_div[0] : m_cnt0 - 1;
      end
      if (bus_we && bus_addr == 8'h18 && bus_wdata[1:0] != 2'd3) m_ctrl[1] = bus_wdata[4:0];
      if (bus_we && bus_addr == 8'h00) m_div[0] = bus_wdata;
      if (bus_we && bus_addr == 8'h10) m_div[1] = bus_wdata;
      if (bus_we && bus_addr == 8'h48) m_mask = bus_wdata[1:0];
      if (bus_we && bus_addr == 8'h4C) m_raw = m_raw & ~bus_wdata[1:0];
      if (fire) m_raw[0] = 1'b1;
      m_time = m_time + 1;
      m_pre  = (m_pre + 1) % 8;
      m_irq  = (m_raw[0] && m_mask[0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check(bus_rdata === m_rdata, m_rtag, bus_rdata, m_rdata);
      check(irq_o === m_irq, "R6", {31'd0, irq_o}, {31'd0, m_irq});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1, v2;
    bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0; rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(irq_o === 1'b0, "R1", {31'd0, irq_o}, 32'd0);
    check(bus_rdata === 32'd0, "R1", bus_rdata, 32'd0);
    rst_n = 1;
    rd(8'h04, v); check(v === 32'd0, "R1", v, 32'd0);
    rd(8'h08, v); check(v === 32'd0, "R1", v, 32'd0);

    // fastest rate, divisor 3, masked in
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h1C);
    rd(8'h04, v); check(v === 32'd3, "R4", v, 32'd3);
    wr(8'h48, 32'd1);
    wr(8'h08, 32'h1E);
    for (int i = 0; i < 12; i++) rd(8'h04, v);
    wr(8'h4C, 32'd1);
    idle(6);
    wr(8'h08, 32'h1D);
    rd(8'h04, v1); idle(10); rd(8'h04, v2);
    check(v1 === v2, "R4", v2, v1);

    // slowest rate, then mask out with a pending bit
    wr(8'h4C, 32'd3);
    wr(8'h00, 32'd2);
    wr(8'h08, 32'h10);
    wr(8'h08, 32'h12);
    for (int i = 0; i < 20; i++) rd(8'h04, v);
    rd(8'h50, v);
    wr(8'h48, 32'd0);
    idle(3);
    check(irq_o === 1'b0, "R6", {31'd0, irq_o}, 32'd0);
    rd(8'h54, v); check(v === 32'd0, "R6", v, 32'd0);
    wr(8'h48, 32'd1);

    // middle rates
    wr(8'h08, 32'h1A);
    for (int i = 0; i < 10; i++) rd(8'h04, v);
    wr(8'h08, 32'h16);
    for (int i = 0; i < 10; i++) rd(8'h04, v);

    // disabled rate codes: counter must not move
    wr(8'h08, 32'h02);
    rd(8'h04, v1); idle(20); rd(8'h04, v2);
    check(v1 === v2, "R3", v2, v1);
    wr(8'h08, 32'h0E);
    rd(8'h04, v1); idle(20); rd(8'h04, v2);
    check(v1 === v2, "R3", v2, v1);

    // illegal command ignored in full
    wr(8'h08, 32'h1F);
    rd(8'h08, v); check(v === 32'h0E, "R4", v, 32'h0E);

    // read-only and unmapped
    wr(8'h08, 32'h1D);
    wr(8'h4C, 32'd3);
    wr(8'h50, 32'd3);
    wr(8'h54, 32'd3);
    rd(8'h50, v); check(v === 32'd0, "R9", v, 32'd0);
    rd(8'h04, v1);
    wr(8'h04, 32'h55);
    rd(8'h04, v2); check(v1 === v2, "R9", v2, v1);
    wr(8'h38, 32'd0);
    rd(8'h20, v); check(v === 32'd0, "R9", v, 32'd0);
    rd(8'h4C, v); check(v === 32'd0, "R9", v, 32'd0);
    rd(8'hFC, v); check(v === 32'd0, "R9", v, 32'd0);

    // time register, back-to-back reads
    @(negedge clk); bus_re = 1; bus_addr = 8'h38;
    @(negedge clk); v1 = bus_rdata;
    @(negedge clk); v2 = bus_rdata; bus_re = 0;
    check(v2 === v1 + 32'd1, "R8", v2, v1 + 32'd1);
    check(v1 > 32'd100, "R8", v1, 32'd101);

    // dormant second channel
    wr(8'h10, 32'd7);
    wr(8'h18, 32'h1E);
    rd(8'h10, v); check(v === 32'd7, "R2", v, 32'd7);
    rd(8'h18, v); check(v === 32'h1E, "R2", v, 32'h1E);
    idle(10);
    rd(8'h14, v); check(v === 32'd0, "R2", v, 32'd0);
    rd(8'h50, v); check(v[1] === 1'b0, "R2", v, 32'd0);

    // divisor 0: expiry on every tick, acknowledge loses to same-cycle expiry
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h1C);
    wr(8'h08, 32'h1E);
    for (int i = 0; i < 4; i++) wr(8'h4C, 32'd1);
    @(negedge clk);
    check(irq_o === 1'b1, "R7", {31'd0, irq_o}, 32'd1);
    wr(8'h08, 32'h1D);
    wr(8'h4C, 32'd1);
    idle(2);
    check(irq_o === 1'b0, "R7", {31'd0, irq_o}, 32'd0);

    idle(4);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule